// File: doc/BRIEF.md
# Interrupt Priority Status Word

This block holds the processor status word that decides whether pending interrupts are accepted. It contains three kinds of state. The first is a global interrupt enable. The second is a 2-bit current priority level. The third is a 2-bit previous priority level, which supports one level of nesting.

Each cycle, the block compares the highest pending request (priorities 1 to 3) against the current level and the enable, and signals an acceptance together with the winning priority. On an acceptance it clears the enable, saves the current level and raises the level to the accepted priority. An interrupt-return strobe restores the saved level and re-enables interrupts.

A pending trap bypasses both the enable and the level mask. The same word also carries sticky per-accumulator overflow flags and a parity flag for the most recent shift result. The word is exposed as a packed 16-bit value for reads, and a write port loads its writable fields.

Top module: `irq_status_word`

## Requirements
- R1: After reset, `psw_o` reads 16'h0000 and neither `take_irq_o` nor `take_trap_o` is asserted.
- R2: `take_irq_o` is asserted only when the enable (bit 14) is 1, no trap is pending, and the highest pending priority is strictly greater than the current level (bits 13:12). `irq_pend_i` bit k requests priority k+1. The highest pending priority wins and is given on `take_lvl_o`, which is 0 when no interrupt is taken.
- R3: `take_trap_o` follows `trap_pend_i` in the same cycle regardless of the enable and the current level, and a pending trap suppresses `take_irq_o`. A trap changes no field of the word.
- R4: A disable strobe clears the enable and an enable strobe sets it, from the next cycle. A register write never changes bit 14. While the enable is 0, no interrupt is taken.
- R5: In the cycle after an acceptance, the enable is 0, the current level equals the accepted priority, and the previous level (bits 11:10) equals the level that was current before.
- R6: In the cycle after an interrupt-return strobe without an acceptance, the current level equals the previous level and the enable is 1; the previous level is unchanged.
- R7: A register write loads the current level from write bits 13:12 and the previous level from write bits 11:10, unless an acceptance or an interrupt return happens in the same cycle.
- R8: An overflow event with index N (2 to 7) and saturation off sets flag bit N-2 of the word. With saturation on, or with an index outside 2..7, the event has no effect. The flags are sticky. A register write loads them from write bits 5:0, and an event in the same cycle as the write still sets its bit.
- R9: On a shift-result strobe, bit 6 becomes 1 if the result has even parity and 0 if it has odd parity. Without the strobe, bit 6 holds, and a register write never changes it.
- R10: Bits 15 and 9:7 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pend_i | input | 3 | Pending interrupts; bit k is priority k+1 |
| trap_pend_i | input | 1 | Pending trap |
| dis_i | input | 1 | Disable-interrupts instruction strobe |
| ena_i | input | 1 | Enable-interrupts instruction strobe |
| iret_i | input | 1 | Interrupt-return instruction strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| ovf_vld_i | input | 1 | Arithmetic overflow event |
| ovf_idx_i | input | 3 | Destination accumulator index of the overflowing result |
| sat_mode_i | input | 1 | Saturation mode active; suppresses overflow flags |
| shift_vld_i | input | 1 | Shift result valid |
| shift_res_i | input | 32 | Shift result used for parity |
| take_irq_o | output | 1 | Interrupt accepted this cycle |
| take_trap_o | output | 1 | Trap taken this cycle |
| take_lvl_o | output | 2 | Priority of the accepted interrupt |
| psw_o | output | 16 | Packed status word |

## Verification
The hardest state to reach is a nested interrupt followed by a return. In that state the previous level is non-zero and differs from what a fresh reset would give, while the enable has been re-armed at a raised level. The stimulus gets there in four steps. It accepts a priority-2 request from level 0, re-enables, and accepts a priority-3 request over it. It then issues a return, after which level 2 must be current with the enable set and a priority-3 request accepted again. Traps are then driven both against that raised level and against a disabled word, to show that they pass the mask without disturbing any field.

// File: rtl/irq_psw_pkg.sv
package irq_psw_pkg;
  localparam int NUM_PRIO = 3;
  localparam int LVL_W    = $clog2(NUM_PRIO + 1);
  localparam int PSW_W    = 16;
  localparam int OVF_W    = 6;
  localparam int ACC_BASE = 2;

  // field positions in the packed word
  localparam int EN_BIT   = 14;
  localparam int CUR_LSB  = 12;
  localparam int PREV_LSB = 10;
  localparam int PAR_BIT  = 6;
  localparam int OVF_LSB  = 0;

  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_psw_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PRIO-1:0] pend_i,
  input  logic                trap_i,
  input  logic                en_i,
  input  lvl_t                cur_i,
  output logic                take_irq_o,
  output logic                take_trap_o,
  output lvl_t                lvl_o
);
  lvl_t top_lvl;

  always_comb begin
    top_lvl = '0;
    for (int k = 0; k < NUM_PRIO; k++) begin
      if (pend_i[k]) top_lvl = lvl_t'(k + 1);
    end
  end

  assign take_trap_o = trap_i;
  assign take_irq_o  = !trap_i && en_i && (top_lvl > cur_i);
  assign lvl_o       = take_irq_o ? top_lvl : '0;

  AST_TRAP_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |-> (take_trap_o && !take_irq_o)); // R3
  AST_IRQ_ABOVE_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (lvl_o > cur_i && lvl_o != '0 && pend_i[lvl_o - 1'b1])); // R2
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !take_irq_o); // R4
  AST_ONE_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_irq_o, take_trap_o})); // R3
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
  import irq_psw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_irq_i,
  input  lvl_t take_lvl_i,
  input  logic dis_i,
  input  logic ena_i,
  input  logic iret_i,
  input  logic wr_en_i,
  input  lvl_t wr_cur_i,
  input  lvl_t wr_prev_i,
  output logic en_o,
  output lvl_t cur_o,
  output lvl_t prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      cur_o  <= '0;
      prev_o <= '0;
    end else if (take_irq_i) begin
      prev_o <= cur_o;
      cur_o  <= take_lvl_i;
      en_o   <= 1'b0;
    end else if (iret_i) begin
      cur_o  <= prev_o;
      en_o   <= 1'b1;
    end else begin
      if (dis_i)      en_o <= 1'b0;
      else if (ena_i) en_o <= 1'b1;
      if (wr_en_i) begin
        cur_o  <= wr_cur_i;
        prev_o <= wr_prev_i;
      end
    end
  end

  AST_ACCEPT_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |=> (!en_o && cur_o == $past(take_lvl_i) && prev_o == $past(cur_o))); // R5
  AST_IRET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && !take_irq_i) |=> (en_o && cur_o == $past(prev_o) && $stable(prev_o))); // R6
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !iret_i) |=> !en_o); // R4
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_psw_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int SHIFT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ovf_vld_i,
  input  logic [IDX_W-1:0]   ovf_idx_i,
  input  logic               sat_mode_i,
  input  logic               wr_en_i,
  input  logic [OVF_W-1:0]   wr_flags_i,
  input  logic               shift_vld_i,
  input  logic [SHIFT_W-1:0] shift_res_i,
  output logic [OVF_W-1:0]   ovf_o,
  output logic               par_o
);
  for (genvar g = 0; g < OVF_W; g++) begin : g_flag
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ACC_BASE + g);
    logic hit;
    assign hit = ovf_vld_i && !sat_mode_i && (ovf_idx_i == MY_IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ovf_o[g] <= 1'b0;
      else if (hit)     ovf_o[g] <= 1'b1;
      else if (wr_en_i) ovf_o[g] <= wr_flags_i[g];
    end

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[g] && !wr_en_i) |=> ovf_o[g]); // R8
    AST_OVF_SAT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovf_o[g] && !wr_en_i && sat_mode_i) |=> !ovf_o[g]); // R8
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          par_o <= 1'b0;
    else if (shift_vld_i) par_o <= ~^shift_res_i;
  end

  AST_PAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_vld_i |=> $stable(par_o)); // R9
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
  import irq_psw_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int SHIFT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PRIO-1:0] irq_pend_i,
  input  logic                trap_pend_i,
  input  logic                dis_i,
  input  logic                ena_i,
  input  logic                iret_i,
  input  logic                wr_en_i,
  input  logic [PSW_W-1:0]    wr_data_i,
  input  logic                ovf_vld_i,
  input  logic [IDX_W-1:0]    ovf_idx_i,
  input  logic                sat_mode_i,
  input  logic                shift_vld_i,
  input  logic [SHIFT_W-1:0]  shift_res_i,
  output logic                take_irq_o,
  output logic                take_trap_o,
  output logic [LVL_W-1:0]    take_lvl_o,
  output logic [PSW_W-1:0]    psw_o
);
  logic             en;
  lvl_t             cur, prev, acc_lvl;
  logic [OVF_W-1:0] ovf;
  logic             par;

  irq_accept u_accept (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (irq_pend_i),
    .trap_i      (trap_pend_i),
    .en_i        (en),
    .cur_i       (cur),
    .take_irq_o  (take_irq_o),
    .take_trap_o (take_trap_o),
    .lvl_o       (acc_lvl)
  );

  irq_level_ctl u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_irq_i (take_irq_o),
    .take_lvl_i (acc_lvl),
    .dis_i      (dis_i),
    .ena_i      (ena_i),
    .iret_i     (iret_i),
    .wr_en_i    (wr_en_i),
    .wr_cur_i   (wr_data_i[CUR_LSB +: LVL_W]),
    .wr_prev_i  (wr_data_i[PREV_LSB +: LVL_W]),
    .en_o       (en),
    .cur_o      (cur),
    .prev_o     (prev)
  );

  irq_flag_bank #(
    .IDX_W   (IDX_W),
    .SHIFT_W (SHIFT_W)
  ) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovf_vld_i   (ovf_vld_i),
    .ovf_idx_i   (ovf_idx_i),
    .sat_mode_i  (sat_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_flags_i  (wr_data_i[OVF_LSB +: OVF_W]),
    .shift_vld_i (shift_vld_i),
    .shift_res_i (shift_res_i),
    .ovf_o       (ovf),
    .par_o       (par)
  );

  assign take_lvl_o = acc_lvl;

  always_comb begin
    psw_o                       = '0;
    psw_o[EN_BIT]               = en;
    psw_o[CUR_LSB +: LVL_W]     = cur;
    psw_o[PREV_LSB +: LVL_W]    = prev;
    psw_o[PAR_BIT]              = par;
    psw_o[OVF_LSB +: OVF_W]     = ovf;
  end

  AST_WRITE_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dis_i && !ena_i && !iret_i && !take_irq_o) |=> $stable(psw_o[EN_BIT])); // R4
  AST_WRITE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !iret_i && !take_irq_o) |=>
      (psw_o[CUR_LSB +: LVL_W] == $past(wr_data_i[CUR_LSB +: LVL_W]) &&
       psw_o[PREV_LSB +: LVL_W] == $past(wr_data_i[PREV_LSB +: LVL_W]))); // R7
endmodule

// File: tb/sim_irq_status_word.sv
`timescale 1ns/1ps
module sim_irq_status_word;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_pend_i;
  logic        trap_pend_i, dis_i, ena_i, iret_i, wr_en_i;
  logic [15:0] wr_data_i;
  logic        ovf_vld_i, sat_mode_i, shift_vld_i;
  logic [2:0]  ovf_idx_i;
  logic [31:0] shift_res_i;
  logic        take_irq_o, take_trap_o;
  logic [1:0]  take_lvl_o;
  logic [15:0] psw_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_status_word u0 (
    .clk_i, .rst_ni, .irq_pend_i, .trap_pend_i, .dis_i, .ena_i, .iret_i,
    .wr_en_i, .wr_data_i, .ovf_vld_i, .ovf_idx_i, .sat_mode_i,
    .shift_vld_i, .shift_res_i, .take_irq_o, .take_trap_o, .take_lvl_o, .psw_o
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    irq_pend_i = '0; trap_pend_i = 0; dis_i = 0; ena_i = 0; iret_i = 0;
    wr_en_i = 0; wr_data_i = '0; ovf_vld_i = 0; ovf_idx_i = '0;
    sat_mode_i = 0; shift_vld_i = 0; shift_res_i = '0;
  endtask

  // advance one edge, then drop all inputs
  task automatic tick();
    @(posedge clk_i); #1;
    clr();
  endtask

  task automatic take(string tag, logic ti, logic tt, logic [1:0] lv);
    #1;
    chk({tag, " take_irq"}, 16'(take_irq_o), 16'(ti));
    chk({tag, " take_trap"}, 16'(take_trap_o), 16'(tt));
    chk({tag, " take_lvl"}, 16'(take_lvl_o), 16'(lv));
  endtask

  task automatic t_reset();
    chk("R1 psw", psw_o, 16'h0000);
    take("R1", 0, 0, 0);
  endtask

  task automatic t_enable();
    wr_en_i = 1; wr_data_i = 16'h4000; tick();
    chk("R4 write enable ignored", psw_o, 16'h0000);
    ena_i = 1; tick();
    chk("R4 ena", psw_o, 16'h4000);
    dis_i = 1; tick();
    chk("R4 dis", psw_o, 16'h0000);
    ena_i = 1; tick();
    chk("R4 ena again", psw_o, 16'h4000);
  endtask

  task automatic t_accept();
    irq_pend_i = 3'b011;
    take("R2 highest of two", 1, 0, 2);
    tick();
    chk("R5 after accept", psw_o, 16'h2000);
    irq_pend_i = 3'b011;
    take("R4 disabled after accept", 0, 0, 0);
    clr();
  endtask

  task automatic t_mask();
    ena_i = 1; tick();
    chk("R4 re-enable", psw_o, 16'h6000);
    irq_pend_i = 3'b011;
    take("R2 equal level masked", 0, 0, 0);
    irq_pend_i = 3'b100;
    take("R2 above level", 1, 0, 3);
    tick();
    chk("R5 nested save", psw_o, 16'h3800);
    ena_i = 1; tick();
    chk("R4 enable at lvl3", psw_o, 16'h7800);
    irq_pend_i = 3'b111;
    take("R2 level3 masks all", 0, 0, 0);
    clr();
  endtask

  task automatic t_iret();
    iret_i = 1; tick();
    chk("R6 return restores", psw_o, 16'h6800);
    irq_pend_i = 3'b100;
    take("R2 after return", 1, 0, 3);
    clr();
  endtask

  task automatic t_trap();
    trap_pend_i = 1; irq_pend_i = 3'b100;
    take("R3 trap over irq", 0, 1, 0);
    tick();
    chk("R3 trap leaves word", psw_o, 16'h6800);
    dis_i = 1; tick();
    chk("R4 dis", psw_o, 16'h2800);
    trap_pend_i = 1;
    take("R3 trap while disabled", 0, 1, 0);
    clr();
    wr_en_i = 1; wr_data_i = 16'h3000; tick();
    chk("R7 write levels", psw_o, 16'h3000);
    trap_pend_i = 1;
    take("R3 trap at level3", 0, 1, 0);
    clr();
  endtask

  task automatic t_write();
    wr_en_i = 1; wr_data_i = 16'hBF80; tick();
    chk("R10 reserved ignored", psw_o, 16'h3C00);
    wr_en_i = 1; wr_data_i = 16'h1000; tick();
    chk("R7 write levels", psw_o, 16'h1000);
  endtask

  task automatic t_ovf();
    ovf_vld_i = 1; ovf_idx_i = 3'd4; tick();
    chk("R8 acc4 sets bit2", psw_o, 16'h1004);
    ovf_vld_i = 1; ovf_idx_i = 3'd7; sat_mode_i = 1; tick();
    chk("R8 saturation masks", psw_o, 16'h1004);
    ovf_vld_i = 1; ovf_idx_i = 3'd1; tick();
    chk("R8 index out of range", psw_o, 16'h1004);
    ovf_vld_i = 1; ovf_idx_i = 3'd7; tick();
    chk("R8 acc7 sets bit5", psw_o, 16'h1024);
    tick();
    chk("R8 sticky", psw_o, 16'h1024);
    wr_en_i = 1; wr_data_i = 16'h1000; tick();
    chk("R8 write zero clears", psw_o, 16'h1000);
    wr_en_i = 1; wr_data_i = 16'h1000; ovf_vld_i = 1; ovf_idx_i = 3'd2; tick();
    chk("R8 event beats write", psw_o, 16'h1001);
    wr_en_i = 1; wr_data_i = 16'h103F; tick();
    chk("R8 write loads flags", psw_o, 16'h103F);
    wr_en_i = 1; wr_data_i = 16'h1000; tick();
    chk("R8 clear all", psw_o, 16'h1000);
  endtask

  task automatic t_parity();
    shift_vld_i = 1; shift_res_i = 32'h3; tick();
    chk("R9 even parity", psw_o, 16'h1040);
    shift_vld_i = 1; shift_res_i = 32'h7; tick();
    chk("R9 odd parity", psw_o, 16'h1000);
    shift_vld_i = 1; shift_res_i = 32'h0; tick();
    chk("R9 zero even", psw_o, 16'h1040);
    wr_en_i = 1; wr_data_i = 16'h1000; tick();
    chk("R9 write ignored", psw_o, 16'h1040);
    shift_res_i = 32'h1; tick();
    chk("R9 hold without strobe", psw_o, 16'h1040);
  endtask

  initial begin
    clr();
    #22 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_enable();
    t_accept();
    t_mask();
    t_iret();
    t_trap();
    t_write();
    t_ovf();
    t_parity();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule